// File: doc/BRIEF.md
# Largest-Deficit Head-Cache Refill Scheduler

This block decides, for the egress side of a two-level packet buffer, which per-queue head cache in fast SRAM is refilled next from a slow bulk memory. It keeps three counters for each of `NQ` queues. The first is the SRAM occupancy. The second is a credited occupancy, which is the occupancy plus any refill still in flight. The third is the number of cells that still sit in bulk memory. Cells reach bulk memory in blocks of `BLK` cells from the ingress side. Once every `BLK` cycles the block picks the eligible queue that lies furthest below its threshold. It then issues one read request for a block of `BLK` cells of that queue.

An outside arbiter drains single cells from the head caches. Its order cannot be predicted. Each departure is accepted in the cycle it is presented. A departure that finds its queue's SRAM empty is reported one cycle later. The refill data is modelled as landing a fixed `RD_LAT` cycles after the request. The per-queue SRAM capacity `CAP` is a parameter. With the default `BLK = 2` and `NQ = 8` it is 9 cells, which covers BLK·(2 + ln NQ) ≈ 8.2. The refill threshold is `CAP - BLK + 1`, so a refill can never overrun the capacity.

A two-state machine sets the decision rhythm. `ST_PICK` is the decision cycle. On `PICK_TO_GAP` the block always moves to `ST_GAP` for `BLK-1` cycles. On `GAP_TO_PICK` it returns to `ST_PICK` once the gap counter reaches zero. When `BLK = 1`, `ST_PICK` loops on itself through `PICK_STAY`. Reset enters `ST_PICK`.

Top module: `lqf_refill_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_valid`, `dep_miss` and `err` are all low.
- R2: A queue is eligible only if its credited occupancy is below the threshold and bulk memory holds at least one block for it. When no queue is eligible, no request is issued, even if every SRAM is empty.
- R3: The eligible queue with the largest deficit wins. The deficit is the threshold minus the credited occupancy. On a tie, the lowest queue index wins.
- R4: Requests are issued only in `ST_PICK` cycles. Consecutive requests are therefore at least `BLK` cycles apart, and exactly `BLK` apart while a queue stays eligible. Each request takes one block (`BLK` cells) from that queue's bulk count.
- R5: A request credits the queue with `BLK` cells at once, so the same cells are never requested twice. With defaults, five blocks loaded into an empty queue yield exactly four requests. A fifth request follows once one cell departs.
- R6: A queue's SRAM occupancy grows by `BLK` at the clock edge `RD_LAT` cycles after the edge that raised `req_valid`. A departure sampled at that same edge still finds the old occupancy.
- R7: A departure lowers the queue's occupancy by one. A departure sampled while the occupancy is zero raises `dep_miss` in the following cycle only, and leaves the occupancy at zero.
- R8: `err` goes high on any miss, or on a refill that would exceed `CAP`. It stays high until reset.
- R9: SRAM occupancy never exceeds `CAP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cell slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | One block of `BLK` cells was written to bulk memory |
| blk_q | input | QW | Queue of that block |
| dep_valid | input | 1 | Arbiter takes one cell from a head cache |
| dep_q | input | QW | Queue of the departing cell |
| req_valid | output | 1 | Bulk-memory read request for one block |
| req_q | output | QW | Queue being refilled |
| dep_miss | output | 1 | Previous cycle's departure found an empty cache |
| err | output | 1 | Sticky miss/overflow flag |

## Verification
A block load or a departure presented before edge E updates the counters at E. A decision at edge E raises `req_valid` in the cycle that follows. The refill lands at edge E+`RD_LAT`, and `dep_miss` shows in the cycle after the departure's edge. The bench releases reset at a falling edge, so the first edge after release is a decision edge. It then places every load on a known edge relative to the decision edges, times each departure from the falling edge at which it saw `req_valid`, and reads every output at a falling edge.

// File: rtl/lqf_pkg.sv
package lqf_pkg;
    typedef enum logic [0:0] {
        ST_PICK = 1'b0,
        ST_GAP  = 1'b1
    } sched_state_t;
endpackage

// File: rtl/lqf_queue_ctr.sv
module lqf_queue_ctr #(
    parameter int BLK    = 2,
    parameter int CAP    = 9,
    parameter int OCC_W  = 5,
    parameter int BULK_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_hit,
    input  logic             req_hit,
    input  logic             land_hit,
    input  logic             dep_hit,
    output logic [OCC_W-1:0] occ,
    output logic [OCC_W-1:0] deficit,
    output logic             miss,
    output logic             ovf
);
    localparam int THRESH = CAP - BLK + 1;
    localparam logic [OCC_W-1:0] BLK_O  = OCC_W'(BLK);
    localparam logic [OCC_W-1:0] THR_O  = OCC_W'(THRESH);
    localparam logic [BULK_W-1:0] BLK_B = BULK_W'(BLK);

    logic [OCC_W-1:0]  credit;
    logic [BULK_W-1:0] bulk;
    logic              take;
    logic              eligible;

    assign take     = dep_hit && (occ != '0);
    assign miss     = dep_hit && (occ == '0);
    assign ovf      = land_hit && ((occ + BLK_O - OCC_W'(take)) > OCC_W'(CAP));
    assign eligible = (credit < THR_O) && (bulk != '0);
    assign deficit  = eligible ? (THR_O - credit) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ    <= '0;
            credit <= '0;
            bulk   <= '0;
        end else begin
            occ    <= occ + (land_hit ? BLK_O : '0) - OCC_W'(take);
            credit <= credit + (req_hit ? BLK_O : '0) - OCC_W'(take);
            bulk   <= bulk + (blk_hit ? BLK_B : '0) - (req_hit ? BLK_B : '0);
        end
    end

    // R2: a request only ever targets an eligible queue
    a_r2_req_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit |-> (credit < THR_O) && (bulk != '0));

    // R9: SRAM occupancy stays within capacity
    a_r9_cap: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(CAP));

    // R7: a served departure lowers occupancy by one when no refill lands
    a_r7_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_hit && !land_hit && occ != '0) |=> occ == $past(occ) - 1'b1);
endmodule

// File: rtl/lqf_pick.sv
module lqf_pick #(
    parameter int NQ    = 8,
    parameter int QW    = 3,
    parameter int OCC_W = 5
) (
    input  logic [NQ-1:0][OCC_W-1:0] deficit,
    output logic                     pick_vld,
    output logic [QW-1:0]            pick_q
);
    logic [OCC_W-1:0] best;

    always_comb begin
        best   = '0;
        pick_q = '0;
        for (int i = 0; i < NQ; i++) begin
            if (deficit[i] > best) begin
                best   = deficit[i];
                pick_q = QW'(i);
            end
        end
        pick_vld = (best != '0);
    end
endmodule

// File: rtl/lqf_read_pipe.sv
module lqf_read_pipe #(
    parameter int QW     = 3,
    parameter int RD_LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [QW-1:0] in_q,
    output logic          out_vld,
    output logic [QW-1:0] out_q
);
    logic [RD_LAT-1:0]         vld_sr;
    logic [RD_LAT-1:0][QW-1:0] q_sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_sr <= '0;
            q_sr   <= '0;
        end else begin
            vld_sr[0] <= in_vld;
            q_sr[0]   <= in_q;
            for (int s = 1; s < RD_LAT; s++) begin
                vld_sr[s] <= vld_sr[s-1];
                q_sr[s]   <= q_sr[s-1];
            end
        end
    end

    assign out_vld = vld_sr[RD_LAT-1];
    assign out_q   = q_sr[RD_LAT-1];
endmodule

// File: rtl/lqf_refill_sched.sv
module lqf_refill_sched
    import lqf_pkg::*;
#(
    parameter int NQ     = 8,
    parameter int BLK    = 2,
    parameter int CAP    = 9,
    parameter int RD_LAT = 3,
    parameter int BULK_W = 12,
    parameter int QW     = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_valid,
    input  logic [QW-1:0] blk_q,
    input  logic          dep_valid,
    input  logic [QW-1:0] dep_q,
    output logic          req_valid,
    output logic [QW-1:0] req_q,
    output logic          dep_miss,
    output logic          err
);
    localparam int OCC_W = $clog2(CAP + BLK + 1) + 1;
    localparam int GAP_W = (BLK > 1) ? $clog2(BLK) : 1;

    sched_state_t state, state_nxt;
    logic [GAP_W-1:0] gap_cnt;

    logic [NQ-1:0][OCC_W-1:0] occ;
    logic [NQ-1:0][OCC_W-1:0] deficit;
    logic [NQ-1:0]            miss_v;
    logic [NQ-1:0]            ovf_v;
    logic                     pick_vld;
    logic [QW-1:0]            pick_q;
    logic                     issue;
    logic                     land_vld;
    logic [QW-1:0]            land_q;

    lqf_pick #(.NQ(NQ), .QW(QW), .OCC_W(OCC_W)) u_pick (
        .deficit (deficit),
        .pick_vld(pick_vld),
        .pick_q  (pick_q)
    );

    assign issue = (state == ST_PICK) && pick_vld;

    lqf_read_pipe #(.QW(QW), .RD_LAT(RD_LAT)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (issue),
        .in_q   (pick_q),
        .out_vld(land_vld),
        .out_q  (land_q)
    );

    for (genvar g = 0; g < NQ; g++) begin : g_q
        lqf_queue_ctr #(.BLK(BLK), .CAP(CAP), .OCC_W(OCC_W), .BULK_W(BULK_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .blk_hit (blk_valid && (blk_q == QW'(g))),
            .req_hit (issue && (pick_q == QW'(g))),
            .land_hit(land_vld && (land_q == QW'(g))),
            .dep_hit (dep_valid && (dep_q == QW'(g))),
            .occ     (occ[g]),
            .deficit (deficit[g]),
            .miss    (miss_v[g]),
            .ovf     (ovf_v[g])
        );

        // R3: the winner's deficit is at least every other deficit
        a_r3_largest: assert property (@(posedge clk) disable iff (!rst_n)
            issue |-> deficit[g] <= deficit[pick_q]);

        // R7: a departure to an empty cache is flagged next cycle
        a_r7_miss: assert property (@(posedge clk) disable iff (!rst_n)
            (dep_valid && dep_q == QW'(g) && occ[g] == '0) |=> dep_miss);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_PICK;
            gap_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_PICK)
                gap_cnt <= GAP_W'(BLK - 2);
            else if (gap_cnt != '0)
                gap_cnt <= gap_cnt - 1'b1;
        end
    end

    // next state: PICK_TO_GAP, GAP_TO_PICK, PICK_STAY (BLK == 1)
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_PICK: state_nxt = (BLK > 1) ? ST_GAP : ST_PICK;
            ST_GAP:  state_nxt = (gap_cnt == '0) ? ST_PICK : ST_GAP;
            default: state_nxt = ST_PICK;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_q     <= '0;
            dep_miss  <= 1'b0;
            err       <= 1'b0;
        end else begin
            req_valid <= issue;
            req_q     <= issue ? pick_q : req_q;
            dep_miss  <= |miss_v;
            err       <= err | (|miss_v) | (|ovf_v);
        end
    end

    // R8: the error flag never clears outside reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R4: back-to-back requests are impossible when a block spans several slots
    if (BLK > 1) begin : g_space
        a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> !req_valid);
    end
endmodule

// File: tb/lqf_refill_sched_test.sv
module lqf_refill_sched_test;
    localparam int PERIOD = 10;
    localparam int NQ = 8, BLK = 2, CAP = 9, RD_LAT = 3, QW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic blk_valid = 1'b0, dep_valid = 1'b0;
    logic [QW-1:0] blk_q = '0, dep_q = '0;
    logic req_valid, dep_miss, err;
    logic [QW-1:0] req_q;

    int total = 0, bad = 0, cyc = 0, nlog = 0;
    int log_q [64];
    int log_c [64];

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lqf_refill_sched #(.NQ(NQ), .BLK(BLK), .CAP(CAP), .RD_LAT(RD_LAT)) uut (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_q(blk_q),
        .dep_valid(dep_valid), .dep_q(dep_q), .req_valid(req_valid),
        .req_q(req_q), .dep_miss(dep_miss), .err(err));

    always @(negedge clk)
        if (rst_n && req_valid && nlog < 64) begin
            log_q[nlog] = int'(req_q);
            log_c[nlog] = cyc;
            nlog++;
        end

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; blk_valid = 1'b0; dep_valid = 1'b0;
        repeat (3) @(negedge clk);
        nlog = 0;
        rst_n = 1'b1;
    endtask

    task automatic load(int q);
        blk_valid = 1'b1; blk_q = QW'(q);
        @(negedge clk);
        blk_valid = 1'b0;
    endtask

    task automatic depart(int q, output logic miss);
        dep_valid = 1'b1; dep_q = QW'(q);
        @(negedge clk);
        dep_valid = 1'b0;
        miss = dep_miss;
    endtask

    task automatic wait_req();
        for (int k = 0; k < 40 && !req_valid; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 req_valid in reset", int'(req_valid), 0);
        check("R1 err in reset", int'(err), 0);
        do_reset();
        @(negedge clk);
        check("R1 req_valid after reset", int'(req_valid), 0);
        check("R1 dep_miss after reset", int'(dep_miss), 0);
    endtask

    task automatic t_no_bulk();
        do_reset();
        repeat (20) @(negedge clk);
        check("R2 no request with empty bulk", nlog, 0);
    endtask

    task automatic t_tie();
        do_reset();
        load(2); load(5);
        repeat (20) @(negedge clk);
        check("R3 tie count", nlog, 2);
        check("R3 tie lowest first", log_q[0], 2);
        check("R3 tie second", log_q[1], 5);
    endtask

    task automatic t_largest();
        do_reset();
        load(4); @(negedge clk); load(6); load(4);
        repeat (20) @(negedge clk);
        check("R3 largest count", nlog, 3);
        check("R3 first", log_q[0], 4);
        check("R3 larger deficit wins over lower index", log_q[1], 6);
        check("R3 third", log_q[2], 4);
    endtask

    task automatic t_credit();
        logic m;
        do_reset();
        for (int i = 0; i < 5; i++) load(0);
        repeat (30) @(negedge clk);
        check("R5 requests until threshold", nlog, 4);
        check("R4 spacing exactly BLK", log_c[1] - log_c[0], BLK);
        check("R4 spacing exactly BLK later", log_c[3] - log_c[2], BLK);
        depart(0, m);
        check("R7 served departure no miss", int'(m), 0);
        repeat (10) @(negedge clk);
        check("R5 refill after departure", nlog, 5);
        check("R5 refill queue", log_q[4], 0);
    endtask

    task automatic t_latency(int extra, int exp_miss);
        logic m;
        do_reset();
        load(3);
        wait_req();
        check("R6 request queue", int'(req_q), 3);
        repeat (RD_LAT - 1 + extra) @(posedge clk);
        @(negedge clk);
        depart(3, m);
        check("R6 landing edge vs departure", int'(m), exp_miss);
    endtask

    task automatic t_drain();
        logic m;
        do_reset();
        load(6);
        repeat (15) @(negedge clk);
        depart(6, m); check("R7 first cell", int'(m), 0);
        depart(6, m); check("R7 second cell", int'(m), 0);
        check("R8 err clear", int'(err), 0);
        depart(6, m); check("R7 empty cache miss", int'(m), 1);
        @(negedge clk);
        check("R7 miss one cycle only", int'(dep_miss), 0);
        depart(6, m); check("R7 occupancy stayed zero", int'(m), 1);
        repeat (10) @(negedge clk);
        check("R8 err sticky", int'(err), 1);
        do_reset();
        @(negedge clk);
        check("R8 err cleared by reset", int'(err), 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_no_bulk();
        t_tie();
        t_largest();
        t_credit();
        t_latency(0, 1);
        t_latency(1, 0);
        t_drain();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule